// File: doc/BRIEF.md
# Serial Port Register Block with Interrupt Identification

This block holds the programmer-visible registers of a classic PC-style serial port and works out which interrupt is pending. A processor reaches it through an eight-register window. Only the low three address bits select a register. Reads return data combinationally in the cycle of the strobe, and their side effects take hold at the clock edge.

Received characters arrive one byte at a time on a valid/ready input, and a separate break pulse marks a line break. Bytes written for transmission leave on a valid/ready output. Bit-level shifting and baud timing sit outside the block.

The interrupt cause is recomputed every cycle from the current state. Received data outranks an empty transmit holding register. A single active-high request line follows the identification register.

Top module: `uart_regfile`

## Requirements
- R1: After reset, line status (offset 5) reads 0x60, identification (offset 2) reads 0x01, `irq` and `tx_valid` are low and `rx_ready` is high.
- R2: Only `bus_addr[2:0]` selects a register, so every higher address bit is ignored on reads and writes.
- R3: When control bit 7 (offset 3) is set, offsets 0 and 1 reach the low and high divisor bytes and leave the enable register untouched. When it is clear, offset 1 is the interrupt enable register (4 bits, upper bits read 0).
- R4: A byte on `rx_data` with `rx_valid` is taken only while status bit 0 (data ready) is clear, and `rx_ready` shows that condition. A taken byte sets bit 0. Reading offset 0 returns the byte and clears bit 0.
- R5: A byte offered while data ready is set is dropped, the held byte is kept, and status bit 1 (overrun) is set. A status read clears bit 1.
- R6: `rx_break` loads the receive buffer with 0x00 and sets status bits 4 (break) and 0. A receive buffer read clears both. A break in the same cycle as that read wins, so both bits stay set.
- R7: Writing offset 0 presents the byte on `tx_data` with `tx_valid` and clears status bits 5 and 6. The byte stays stable until `tx_ready`. The handshake drops `tx_valid`, sets bits 5 and 6, and marks a transmit-empty event pending. A write in the same cycle as the handshake loads the new byte, which stays valid.
- R8: Identification reads 0x04 when data ready and enable bit 0 are set. Otherwise it reads 0x02 when a transmit-empty event is pending and enable bit 1 is set. Otherwise it reads 0x01. No event is pending after reset.
- R9: Reading identification while it shows 0x02 cancels the pending transmit-empty event. A read that shows 0x04 leaves the event pending.
- R10: `irq` is high exactly when identification bit 0 is zero, in the same cycle.
- R11: Offsets 4, 6 and 7 read 0x00. Writes to offsets 2, 4, 5, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address; low 3 bits decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Line break detected |
| rx_ready | output | 1 | Receive buffer free |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Downstream accepts transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land on the same clock edge. A break can arrive while the processor reads the receive buffer, and a new transmit write can coincide with the downstream handshake for the previous byte. The bench drives each pair on a single edge. For the first pair it checks that the read returns the old byte and that break and data ready remain set afterwards. For the second it checks that the new byte is presented, still valid, and that no transmit-empty event was left pending. Random traffic over receive, transmit, enable and identification accesses is scored against a bench-side register model.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_break,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              irq
);
  localparam logic [7:0] ID_NONE = 8'h01;
  localparam logic [7:0] ID_RX   = 8'h04;
  localparam logic [7:0] ID_TX   = 8'h02;

  logic [2:0]  reg_sel;
  logic [7:0]  rbuf, ctrl;
  logic [3:0]  ena;
  logic [15:0] divisor;
  logic        rdy, ovr, brk, hold_empty, shift_empty, tx_pend;
  logic [7:0]  ident, status;
  logic        dlab, wr_hold, rd_buf, rd_ident, rd_status, rx_take, tx_done;

  assign reg_sel   = bus_addr[2:0];
  assign dlab      = ctrl[7];
  assign wr_hold   = bus_wr && reg_sel == 3'd0 && !dlab;
  assign rd_buf    = bus_rd && reg_sel == 3'd0 && !dlab;
  assign rd_ident  = bus_rd && reg_sel == 3'd2;
  assign rd_status = bus_rd && reg_sel == 3'd5;
  assign rx_ready  = !rdy;
  assign rx_take   = rx_valid && !rdy && !rx_break;
  assign tx_done   = tx_valid && tx_ready;

  assign ident  = (rdy && ena[0]) ? ID_RX : (tx_pend && ena[1]) ? ID_TX : ID_NONE;
  assign irq    = !ident[0];
  assign status = {1'b0, shift_empty, hold_empty, brk, 2'b00, ovr, rdy};

  always_comb begin
    case (reg_sel)
      3'd0:    bus_rdata = dlab ? divisor[7:0] : rbuf;
      3'd1:    bus_rdata = dlab ? divisor[15:8] : {4'b0000, ena};
      3'd2:    bus_rdata = ident;
      3'd3:    bus_rdata = ctrl;
      3'd5:    bus_rdata = status;
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      ena     <= '0;
      divisor <= '0;
    end else if (bus_wr) begin
      case (reg_sel)
        3'd0: if (dlab) divisor[7:0] <= bus_wdata;
        3'd1: if (dlab) divisor[15:8] <= bus_wdata; else ena <= bus_wdata[3:0];
        3'd3: ctrl <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbuf <= '0;
      rdy  <= 1'b0;
      brk  <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (rx_break) begin
        rbuf <= 8'h00;
        rdy  <= 1'b1;
        brk  <= 1'b1;
      end else if (rx_take) begin
        rbuf <= rx_data;
        rdy  <= 1'b1;
      end else if (rd_buf) begin
        rdy <= 1'b0;
        brk <= 1'b0;
      end
      if (rx_valid && rdy && !rx_break) ovr <= 1'b1;
      else if (rd_status)               ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid    <= 1'b0;
      tx_data     <= '0;
      hold_empty  <= 1'b1;
      shift_empty <= 1'b1;
      tx_pend     <= 1'b0;
    end else if (wr_hold) begin
      tx_valid    <= 1'b1;
      tx_data     <= bus_wdata;
      hold_empty  <= 1'b0;
      shift_empty <= 1'b0;
      tx_pend     <= 1'b0;
    end else if (tx_done) begin
      tx_valid    <= 1'b0;
      hold_empty  <= 1'b1;
      shift_empty <= 1'b1;
      tx_pend     <= 1'b1;
    end else if (rd_ident && ident == ID_TX) begin
      tx_pend <= 1'b0;
    end
  end

  // R4
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !rx_break |=> !rx_ready && bus_rdata == $past(rx_data) || $past(dlab) || reg_sel != 3'd0);
  // R5
  rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !rx_break |=> ovr && $stable(rbuf));
  // R6
  rx_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> rdy && brk && rbuf == 8'h00);
  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !wr_hold |=> tx_valid && $stable(tx_data));
  // R7
  tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && !wr_hold |=> !tx_valid && hold_empty && tx_pend);
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rdy && ena[0]) || (tx_pend && ena[1]));
endmodule

// File: tb/tb_uart_regfile.sv
module tb_uart_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        rx_valid = 1'b0, rx_break = 1'b0, tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;

  int checks = 0, errors = 0;

  uart_regfile dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  bit m_dr, m_bi, m_oe, m_thre, m_pend, m_busy;
  logic [7:0] m_rbr, m_tx;
  logic [3:0] m_ier;

  function automatic logic [7:0] exp_iir();
    if (m_dr && m_ier[0]) return 8'h04;
    if (m_pend && m_ier[1]) return 8'h02;
    return 8'h01;
  endfunction

  function automatic logic [7:0] exp_lsr();
    return {1'b0, m_thre, m_thre, m_bi, 2'b00, m_oe, m_dr};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rx(input logic [7:0] d, input bit b);
    @(negedge clk); rx_data = d; rx_valid = !b; rx_break = b;
    @(negedge clk); rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  task automatic hs();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    check("R1 rx_ready", {7'b0, rx_ready}, 8'h01);
    rd(16'd5, d); check("R1 lsr", d, 8'h60);
    rd(16'd2, d); check("R1 iir", d, 8'h01);
    // R2
    wr(16'hABC3, 8'h1B); rd(16'h0003, d); check("R2 alias write", d, 8'h1B);
    rd(16'hF00B, d); check("R2 alias read", d, 8'h1B);
    wr(16'd3, 8'h03);
    // R3
    wr(16'd1, 8'hF5); rd(16'd1, d); check("R3 ier", d, 8'h05);
    wr(16'd3, 8'h83); wr(16'd0, 8'h34); wr(16'd1, 8'h12);
    rd(16'd0, d); check("R3 div lo", d, 8'h34);
    rd(16'd1, d); check("R3 div hi", d, 8'h12);
    check("R3 no tx", {7'b0, tx_valid}, 8'h00);
    wr(16'd3, 8'h03); rd(16'd1, d); check("R3 ier kept", d, 8'h05);
    // R11
    rd(16'd4, d); check("R11 off4", d, 8'h00);
    rd(16'd6, d); check("R11 off6", d, 8'h00);
    rd(16'd7, d); check("R11 off7", d, 8'h00);
    wr(16'd2, 8'hFF); wr(16'd5, 8'hFF); wr(16'd7, 8'hFF);
    rd(16'd3, d); check("R11 lcr", d, 8'h03);
    rd(16'd1, d); check("R11 ier", d, 8'h05);
    rd(16'd5, d); check("R11 lsr", d, 8'h60);
    // R8 no pending after reset
    wr(16'd1, 8'h02); rd(16'd2, d); check("R8 reset pend", d, 8'h01);
    // R7
    wr(16'd0, 8'h5A);
    check("R7 valid", {7'b0, tx_valid}, 8'h01); check("R7 data", tx_data, 8'h5A);
    rd(16'd5, d); check("R7 lsr busy", d, 8'h00);
    check("R7 stable", tx_data, 8'h5A);
    @(negedge clk); tx_ready = 1'b1; bus_addr = 16'd0; bus_wdata = 8'hC3; bus_wr = 1'b1;
    @(negedge clk); tx_ready = 1'b0; bus_wr = 1'b0;
    check("R7 overlap valid", {7'b0, tx_valid}, 8'h01); check("R7 overlap data", tx_data, 8'hC3);
    rd(16'd2, d); check("R7 overlap no pend", d, 8'h01);
    hs();
    check("R7 released", {7'b0, tx_valid}, 8'h00);
    rd(16'd5, d); check("R7 lsr empty", d, 8'h60);
    // R10
    check("R10 irq high", {7'b0, irq}, 8'h01);
    // R9
    rd(16'd2, d); check("R9 first", d, 8'h02);
    rd(16'd2, d); check("R9 cancelled", d, 8'h01);
    check("R10 irq low", {7'b0, irq}, 8'h00);
    // R8 priority
    wr(16'd0, 8'h66); hs(); wr(16'd1, 8'h03); rx(8'h77, 0);
    rd(16'd2, d); check("R8 rx first", d, 8'h04);
    rd(16'd0, d); check("R4 rbr", d, 8'h77);
    rd(16'd2, d); check("R9 rx read keeps pend", d, 8'h02);
    rd(16'd2, d); check("R9 cleared", d, 8'h01);
    // R5
    rx(8'h11, 0);
    check("R4 rx_ready low", {7'b0, rx_ready}, 8'h00);
    rx(8'h22, 0);
    rd(16'd5, d); check("R5 lsr", d, 8'h63);
    rd(16'd5, d); check("R5 oe cleared", d, 8'h61);
    rd(16'd0, d); check("R5 kept byte", d, 8'h11);
    rd(16'd5, d); check("R4 dr cleared", d, 8'h60);
    // R6
    rx(8'hEE, 1);
    rd(16'd5, d); check("R6 lsr", d, 8'h71);
    rd(16'd0, d); check("R6 zero", d, 8'h00);
    rd(16'd5, d); check("R6 cleared", d, 8'h60);
    rx(8'h99, 0);
    @(negedge clk); bus_addr = 16'd0; bus_rd = 1'b1; rx_break = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; rx_break = 1'b0;
    check("R6 overlap read", d, 8'h99);
    rd(16'd5, d); check("R6 break wins", d, 8'h71);
    rd(16'd0, d); check("R6 overlap rbr", d, 8'h00);

    m_dr = 0; m_bi = 0; m_oe = 0; m_thre = 1; m_pend = 0; m_busy = 0;
    m_rbr = 8'h00; m_ier = 4'h3; m_tx = 8'h66;
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] v;
      op = $urandom_range(0, 7);
      v = 8'($urandom);
      case (op)
        0: begin rx(v, 0); if (!m_dr) begin m_rbr = v; m_dr = 1; end else m_oe = 1; end
        1: begin rd(16'd0, d); check("R4 rand rbr", d, m_rbr); m_dr = 0; m_bi = 0; end
        2: begin rd(16'd2, d); check("R8 rand iir", d, exp_iir()); if (exp_iir() == 8'h02) m_pend = 0; end
        3: begin rd(16'd5, d); check("R5 rand lsr", d, exp_lsr()); m_oe = 0; end
        4: begin wr(16'd1, v); m_ier = v[3:0]; end
        5: if (!m_busy) begin
             wr(16'd0, v); m_busy = 1; m_thre = 0; m_pend = 0; m_tx = v;
             check("R7 rand data", tx_data, m_tx);
           end
        6: begin hs(); if (m_busy) begin m_busy = 0; m_thre = 1; m_pend = 1; end end
        default: begin rx(v, 1); m_rbr = 8'h00; m_dr = 1; m_bi = 1; end
      endcase
      check("R10 rand irq", {7'b0, irq}, {7'b0, exp_iir() != 8'h01});
      check("R7 rand valid", {7'b0, tx_valid}, {7'b0, m_busy});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule